// File: doc/BRIEF.md
# Breathing PWM Duty Sweep Generator

This block drives a single pulse-width-modulated output whose duty cycle rises and falls in a repeating triangle, giving a slow "breathing" brightness ramp on an LED or similar load. A free-running period counter divides the clock into frames of `PERIOD` cycles. At the end of every frame a duty register moves by `STEP` counts, and the output in each frame stays low for the first `D` cycles and high for the rest, where `D` is that frame's duty value.

The sweep direction is held in a one-bit flag. The turn-around tests are written as inequalities on the value before the update, and every update saturates into the range 0 to `PERIOD`. Because of this, a step that does not divide the period still reverses cleanly at both ends, and any duty value the register might hold is steered back into the sweep. A synchronous active-high reset puts the counter, the duty, the direction and the output into a known state. The output is held low for the whole first frame after reset, so no partial pulse can appear.

With the default parameters (a 50000-cycle frame and a step of 50) a 50 MHz clock gives 1 ms frames and a full up-and-down sweep of about 2 s.

Top module: `pwm_breathe`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pwm_o` is low in the following cycle, and the counter, the duty (0) and the direction (increasing) return to their initial values.
- R2: Each frame lasts exactly `PERIOD` cycles. In every frame after the first, `pwm_o` is high for exactly `PERIOD - D` cycles, where `D` is that frame's duty.
- R3: The duty is 0 in the first frame after reset. While the sweep is increasing, each frame end adds `STEP`, so the second frame uses `STEP`.
- R4: On an increasing update where old duty + `STEP` >= `PERIOD`, the duty becomes `PERIOD` and the direction becomes decreasing. A frame with duty `PERIOD` keeps `pwm_o` low throughout.
- R5: On a decreasing update where old duty <= `STEP`, the duty becomes 0 and the direction becomes increasing. Otherwise `STEP` is subtracted. A frame with duty 0 keeps `pwm_o` high throughout.
- R6: Within a frame, with the cycle index c running from 0 at the first cycle after the wrap, `pwm_o` is high exactly when c >= D. The output therefore rises at most once per frame and falls only at c = 0.
- R7: For the first `PERIOD` cycles after reset is released (the first frame), `pwm_o` stays low.
- R8: When `STEP` does not divide `PERIOD`, the sweep still reverses at both ends by saturation, and the duty never leaves the range 0 to `PERIOD`.
- R9: A reset asserted in the middle of a sweep restarts the pattern from duty 0 with the direction increasing, exactly as after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_o | output | 1 | Registered PWM output |

## Verification
A wrong count, duty or direction shows at `pwm_o` within one frame. A wrong counter moves the rising edge or the frame boundary. A wrong duty changes the number of high cycles in that frame. A missed or early turn-around makes the high-cycle count go the wrong way from the next frame on. The bench therefore compares every output cycle against an arithmetic sweep model, using one configuration whose step does not divide the period and one whose step does. It also totals the high cycles per frame, so that an error is caught in the frame where it first appears.

// File: rtl/pwm_breathe_pkg.sv
package pwm_breathe_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;

    // Increase with saturation at ceil_v.
    function automatic logic [31:0] rise_sat(input logic [31:0] cur,
                                             input logic [31:0] step,
                                             input logic [31:0] ceil_v);
        logic [31:0] sum;
        sum = cur + step;
        return (sum > ceil_v) ? ceil_v : sum;
    endfunction

    // Decrease with saturation at zero; an out-of-range start is pulled to ceil_v.
    function automatic logic [31:0] fall_sat(input logic [31:0] cur,
                                             input logic [31:0] step,
                                             input logic [31:0] ceil_v);
        logic [31:0] dif;
        dif = (cur <= step) ? 32'd0 : (cur - step);
        return (dif > ceil_v) ? ceil_v : dif;
    endfunction

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
    parameter int unsigned PERIOD = 50000,
    localparam int unsigned CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = (cnt_q == CNT_W'(PERIOD - 1));

    always_comb begin
        if (rst || wrap_o) cnt_nxt_o = '0;
        else               cnt_nxt_o = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_nxt_o;

    assign cnt_o = cnt_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < PERIOD);                                          // R2
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> cnt_q == $past(cnt_q) + 1'b1);                     // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_q == '0);                                       // R2

endmodule

// File: rtl/pwm_duty_sweeper.sv
module pwm_duty_sweeper
    import pwm_breathe_pkg::*;
#(
    parameter int unsigned PERIOD = 50000,
    parameter int unsigned STEP   = 50,
    localparam int unsigned DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DUTY_W-1:0] duty_nxt_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        sweep_dir_e        dir;
    } sweep_st_t;

    sweep_st_t st_q, st_n;

    always_comb begin
        st_n = st_q;
        if (wrap_i) begin
            if (st_q.dir == DIR_UP) begin
                st_n.duty = DUTY_W'(rise_sat(32'(st_q.duty), STEP, PERIOD));
                if (32'(st_q.duty) + STEP >= PERIOD) st_n.dir = DIR_DOWN;
            end else begin
                st_n.duty = DUTY_W'(fall_sat(32'(st_q.duty), STEP, PERIOD));
                if (32'(st_q.duty) <= STEP) st_n.dir = DIR_UP;
            end
        end
        if (rst) begin
            st_n.duty = '0;
            st_n.dir  = DIR_UP;
        end
    end

    always_ff @(posedge clk) st_q <= st_n;

    assign duty_o     = st_q.duty;
    assign duty_nxt_o = st_n.duty;

    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(st_q.duty) <= PERIOD);                                      // R8
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(st_q.duty));                                // R6
    AST_RISE_STEP: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && st_q.dir == DIR_UP && 32'(st_q.duty) + STEP < PERIOD)
        |=> 32'(st_q.duty) == 32'($past(st_q.duty)) + STEP && st_q.dir == DIR_UP); // R3
    AST_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && st_q.dir == DIR_UP && 32'(st_q.duty) + STEP >= PERIOD)
        |=> 32'(st_q.duty) == PERIOD && st_q.dir == DIR_DOWN);          // R4
    AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && st_q.dir == DIR_DOWN && 32'(st_q.duty) <= STEP)
        |=> st_q.duty == '0 && st_q.dir == DIR_UP);                     // R5

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cnt_nxt_i,
    input  logic [DUTY_W-1:0] duty_nxt_i,
    output logic              pwm_o
);

    logic armed_q, armed_n;
    logic pwm_q, pwm_n;

    always_comb begin
        armed_n = (armed_q || wrap_i) && !rst;
        pwm_n   = armed_n && (DUTY_W'(cnt_nxt_i) >= duty_nxt_i);
    end

    always_ff @(posedge clk) begin
        armed_q <= armed_n;
        pwm_q   <= pwm_n;
    end

    assign pwm_o = pwm_q;

    AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> !pwm_q);                                           // R7
    AST_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_q) |-> cnt_i == '0);                                  // R6

endmodule

// File: rtl/pwm_breathe.sv
module pwm_breathe #(
    parameter int unsigned PERIOD = 50000,
    parameter int unsigned STEP   = 50
) (
    input  logic clk,
    input  logic rst,
    output logic pwm_o
);

    localparam int unsigned CNT_W  = $clog2(PERIOD);
    localparam int unsigned DUTY_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [DUTY_W-1:0] duty, duty_nxt;
    logic              wrap;

    pwm_frame_counter #(.PERIOD(PERIOD)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap)
    );

    pwm_duty_sweeper #(.PERIOD(PERIOD), .STEP(STEP)) u_sweep (
        .clk        (clk),
        .rst        (rst),
        .wrap_i     (wrap),
        .duty_o     (duty),
        .duty_nxt_o (duty_nxt)
    );

    pwm_out_stage #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .wrap_i     (wrap),
        .cnt_i      (cnt),
        .cnt_nxt_i  (cnt_nxt),
        .duty_nxt_i (duty_nxt),
        .pwm_o      (pwm_o)
    );

    initial begin
        AST_PARAM_OK: assert (PERIOD >= 2 && STEP >= 1 && STEP <= PERIOD); // R8
    end

    AST_OUT_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> DUTY_W'(cnt) == duty);                         // R6

endmodule

// File: tb/pwm_breathe_tb.sv
module pwm_breathe_tb;

    localparam int P0 = 20;
    localparam int S0 = 3;
    localparam int P1 = 16;
    localparam int S1 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm0, pwm1;

    always #10 clk = ~clk;

    pwm_breathe #(.PERIOD(P0), .STEP(S0)) u_dut (
        .clk(clk), .rst(rst), .pwm_o(pwm0));
    pwm_breathe #(.PERIOD(P1), .STEP(S1)) u_dut_even (
        .clk(clk), .rst(rst), .pwm_o(pwm1));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit after_mid = 1'b0;
    int per [2] = '{P0, P1};
    int stp [2] = '{S0, S1};
    int md  [2];
    bit mup [2];
    int hc  [2];
    int t;

    task automatic chk_bit(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s t=%0d actual=%b expected=%b", tag, what, t, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, what, t, act, exp);
        end
    endtask

    function automatic logic out_of(int i);
        return (i == 0) ? pwm0 : pwm1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            md[i] = 0; mup[i] = 1'b1; hc[i] = 0;
        end
        t = 0;
    endtask

    // Called at a falling edge; t counts rising edges since reset release.
    task automatic step_cycle();
        for (int i = 0; i < 2; i++) begin
            int n, c;
            logic exp, act;
            string tag;
            n = t / per[i];
            c = t % per[i];
            exp = (n >= 1) && (c >= md[i]);
            act = out_of(i);
            if (n == 0)                                   tag = "R7";
            else if (i == 0 && (md[i] == per[i] || md[i] == 0)) tag = "R8";
            else if (md[i] == per[i])                     tag = "R4";
            else if (md[i] == 0)                          tag = "R5";
            else if (mup[i])                              tag = "R3";
            else                                          tag = "R6";
            chk_bit(tag, act, exp, $sformatf("pwm inst%0d frame%0d idx%0d duty%0d", i, n, c, md[i]));
            if (act === 1'b1) hc[i]++;
            if (c == per[i] - 1) begin
                if (n == 0)
                    chk_int("R7", hc[i], 0, $sformatf("high count inst%0d first frame", i));
                else if (after_mid && n == 1)
                    chk_int("R9", hc[i], per[i] - md[i], $sformatf("high count inst%0d after mid reset", i));
                else
                    chk_int("R2", hc[i], per[i] - md[i], $sformatf("high count inst%0d frame%0d", i, n));
                hc[i] = 0;
                if (mup[i]) begin
                    md[i] = md[i] + stp[i];
                    if (md[i] >= per[i]) begin md[i] = per[i]; mup[i] = 1'b0; end
                end else begin
                    md[i] = md[i] - stp[i];
                    if (md[i] <= 0) begin md[i] = 0; mup[i] = 1'b1; end
                end
            end
        end
        t++;
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            chk_bit("R1", pwm0, 1'b0, "pwm inst0 in reset");
            chk_bit("R1", pwm1, 1'b0, "pwm inst1 in reset");
        end
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        step_cycle();
        repeat (900) begin
            @(negedge clk);
            step_cycle();
        end
        // Reset in the middle of a sweep
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_bit("R1", pwm0, 1'b0, "pwm inst0 mid reset");
            chk_bit("R9", pwm1, 1'b0, "pwm inst1 mid reset");
        end
        rst = 1'b0;
        after_mid = 1'b1;
        model_reset();
        step_cycle();
        repeat (400) begin
            @(negedge clk);
            step_cycle();
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired t=%0d actual=running expected=done", t);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule